// File: doc/BRIEF.md
# Pseudo-Random Memory Block Self-Test Engine

This engine runs a built-in self-test over an external RAM. It splits the RAM into equal blocks and handles them one at a time. For each block it generates a pattern, streams it to a memory controller as a write burst and waits a programmable number of cycles. It then requests a read burst of the same block and compares every returned byte against the same pattern, generated a second time. Mismatching bytes add to an error count that spans the whole run. Nothing is buffered: the generator's state is saved when a block begins and restored before the read phase, so the expected bytes come out again in the same order.

Two pattern sources are available. The first is a 32-bit xoroshiro-style iterator. Its 16-bit output sum is taken from the current state and kept apart from the state update. The second folds the byte address onto itself with XOR, which gives a rolling pattern that depends on the seed. A test with a long write-to-read wait shows where data retention starts to fail. The controller side uses one request channel and two byte streams, all valid/ready. Control and status pins are plain levels or pulses.

Top module: `mbist_engine`

## Requirements
- R1: A one-cycle `start` while `busy` is low launches a run. It captures `mode_addr`, `seed` and `wait_cycles`, clears `err_count` and `done`, and raises `busy` from the next cycle. Later changes to those inputs, and `start` while `busy`, have no effect. When the last block has been compared, `done` goes high and `busy` goes low in the same cycle.
- R2: Blocks are tested from index BLOCKS-1 down to 0. Each block takes, in this order:
  - one write request (`req_write`=1) at byte address index*BLOCK_BYTES;
  - BLOCK_BYTES write beats, where beat i holds the byte for address base+i;
  - one read request (`req_write`=0) at the same address;
  - BLOCK_BYTES read beats.
- R3: With `mode_addr`=0 the generator state is lo=`seed[15:0]`, hi=`seed[31:16]`.
  - Each byte is bits [15:8] of the 16-bit sum lo+hi, taken from the current state.
  - The state then advances: t=hi^lo; lo=rotl16(lo,13)^t^(t<<5); hi=rotl16(t,10).
- R4: The generator state carries on from one block to the next, so each block gets new bytes. The read phase of a block uses the same byte sequence as that block's write phase.
- R5: With `mode_addr`=1, each byte is `seed[7:0]` XORed with every 8-bit slice of the byte address, the address being zero-extended to whole bytes.
- R6: With W=`wait_cycles`, the read request is not asserted until W+1 clock edges after the edge that accepts the block's last write beat. If `req_ready` is high it is accepted on exactly that edge.
- R7: Each accepted read beat whose data differs from the expected byte adds one to `err_count`. The count saturates at 2^ERR_W-1.
- R8: Back-pressure rules:
  - `req_valid` keeps its address and type, and `wd_valid` keeps its data, until the matching ready is high.
  - `rd_ready` is high only during a read burst, and a read beat is taken only on `rd_valid`&&`rd_ready`.
  - `rd_data` has no effect when `rd_ready` is low.
- R9: While `rst_n` is low, `busy`, `done`, `req_valid`, `wd_valid` and `rd_ready` are 0 and `err_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run launch pulse |
| mode_addr | input | 1 | 0: xoroshiro pattern, 1: address-fold pattern |
| seed | input | 32 | Generator seed / fold byte |
| wait_cycles | input | DLY_W | Write-to-read wait per block |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Burst request accepted |
| req_write | output | 1 | 1 write burst, 0 read burst |
| req_addr | output | log2(BLOCKS*BLOCK_BYTES) | Burst start byte address |
| wd_valid | output | 1 | Write byte valid |
| wd_ready | input | 1 | Write byte accepted |
| wd_data | output | 8 | Write byte |
| rd_valid | input | 1 | Read byte valid |
| rd_ready | output | 1 | Engine accepts read byte |
| rd_data | input | 8 | Read byte |
| done | output | 1 | Run complete |
| busy | output | 1 | Run in progress |
| err_count | output | ERR_W | Saturating mismatch count |

## Verification
The assertions assume the following about the controller:
- Read data arrives only after the matching read request has been accepted.
- `start` is a single-cycle pulse.
- `rst_n` is asynchronous and takes effect immediately.

The bench's memory model keeps to these rules. It answers reads only after a read request has been accepted. While no read is pending it drives junk with `rd_valid` high, to show that the engine ignores it. It throttles every ready and valid with fixed cycle patterns, so the hold rules are exercised against real back-pressure.

// File: rtl/mbist_pkg.sv
`timescale 1ns/1ps
package mbist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WREQ, ST_WDATA, ST_WAIT, ST_RREQ, ST_RDATA, ST_NEXT
  } mbist_st_e;

  typedef struct packed {
    logic [15:0] hi;
    logic [15:0] lo;
  } prng_st_t;

  // one iteration of the 32-bit state; the output sum is formed elsewhere
  function automatic prng_st_t prng_advance(input prng_st_t s);
    prng_st_t   n;
    logic [15:0] t;
    t    = s.hi ^ s.lo;
    n.lo = {s.lo[2:0], s.lo[15:3]} ^ t ^ {t[10:0], 5'b0};
    n.hi = {t[5:0], t[15:6]};
    return n;
  endfunction

endpackage

// File: rtl/mbist_prng.sv
`timescale 1ns/1ps
module mbist_prng
  import mbist_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] seed,
  input  logic        take,
  input  logic        restore,
  input  logic        adv,
  output logic [7:0]  byte_o
);

  prng_st_t    st_q, snap_q;
  logic [15:0] sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (load) begin
      st_q <= seed;
    end else if (restore) begin
      st_q <= snap_q;
    end else if (adv) begin
      st_q <= prng_advance(st_q);
    end
  end

  // block-start checkpoint, replayed for the compare burst
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap_q <= '0;
    else if (take) snap_q <= st_q;
  end

  assign sum    = st_q.lo + st_q.hi;
  assign byte_o = sum[15:8];

  // R4: checkpoint held while the block's write burst runs
  a_r4_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !take) |=> $stable(snap_q));

endmodule

// File: rtl/mbist_seq.sv
`timescale 1ns/1ps
module mbist_seq
  import mbist_pkg::*;
#(
  parameter  int BLOCKS      = 65536,
  parameter  int BLOCK_BYTES = 128,
  parameter  int DLY_W       = 16,
  localparam int BW          = $clog2(BLOCKS),
  localparam int IW          = $clog2(BLOCK_BYTES),
  localparam int AW          = BW + IW
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DLY_W-1:0] wait_cycles,
  input  logic             req_ready,
  input  logic             wd_ready,
  input  logic             rd_valid,
  output logic             req_valid,
  output logic             req_write,
  output logic [AW-1:0]    req_addr,
  output logic             wd_valid,
  output logic             rd_ready,
  output logic [AW-1:0]    byte_addr,
  output logic             wr_beat,
  output logic             rd_beat,
  output logic             launch,
  output logic             take_snap,
  output logic             restore,
  output logic             done,
  output logic             busy
);

  localparam logic [IW-1:0]    LAST_BEAT = IW'(BLOCK_BYTES - 1);
  localparam logic [DLY_W-1:0] DLY_ONE   = DLY_W'(1);

  generate
    if ((1 << BW) != BLOCKS || (1 << IW) != BLOCK_BYTES || BW < 1 || IW < 1)
      $error("BLOCKS and BLOCK_BYTES must be powers of two of at least 2");
  endgenerate

  mbist_st_e        st_q;
  logic [BW-1:0]    blk_q;
  logic [IW-1:0]    beat_q;
  logic [DLY_W-1:0] dly_cfg_q, dly_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      blk_q     <= '0;
      beat_q    <= '0;
      dly_cfg_q <= '0;
      dly_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q      <= ST_WREQ;
          blk_q     <= '1;
          done_q    <= 1'b0;
          dly_cfg_q <= wait_cycles;
        end
        ST_WREQ: if (req_ready) begin
          st_q   <= ST_WDATA;
          beat_q <= '0;
        end
        ST_WDATA: if (wd_ready) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == LAST_BEAT) begin
            if (dly_cfg_q == '0) begin
              st_q <= ST_RREQ;
            end else begin
              st_q  <= ST_WAIT;
              dly_q <= dly_cfg_q;
            end
          end
        end
        ST_WAIT: begin
          dly_q <= dly_q - 1'b1;
          if (dly_q == DLY_ONE) st_q <= ST_RREQ;
        end
        ST_RREQ: if (req_ready) begin
          st_q   <= ST_RDATA;
          beat_q <= '0;
        end
        ST_RDATA: if (rd_valid) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == LAST_BEAT) st_q <= ST_NEXT;
        end
        ST_NEXT: begin
          if (blk_q == '0) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            blk_q <= blk_q - 1'b1;
            st_q  <= ST_WREQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid = (st_q == ST_WREQ) || (st_q == ST_RREQ);
  assign req_write = (st_q == ST_WREQ);
  assign req_addr  = {blk_q, {IW{1'b0}}};
  assign wd_valid  = (st_q == ST_WDATA);
  assign rd_ready  = (st_q == ST_RDATA);
  assign byte_addr = {blk_q, beat_q};
  assign wr_beat   = wd_valid && wd_ready;
  assign rd_beat   = rd_ready && rd_valid;
  assign launch    = (st_q == ST_IDLE) && start;
  assign take_snap = (st_q == ST_WREQ);
  assign restore   = (st_q == ST_RREQ);
  assign done      = done_q;
  assign busy      = (st_q != ST_IDLE);

  // R8: request held with stable payload under back-pressure
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write)));

  // R6: wait state never entered or kept with an exhausted counter
  a_r6_wait_live: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> (dly_q != '0));

  // R1: completion and activity are exclusive
  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2: block 0 is the final block of a run
  a_r2_last_block: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NEXT && blk_q == '0) |=> (done && !busy));

  // R1: start while running leaves the block index alone
  a_r1_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && st_q != ST_NEXT) |=> $stable(blk_q));

endmodule

// File: rtl/mbist_engine.sv
`timescale 1ns/1ps
module mbist_engine
  import mbist_pkg::*;
#(
  parameter  int BLOCKS      = 65536,
  parameter  int BLOCK_BYTES = 128,
  parameter  int DLY_W       = 16,
  parameter  int ERR_W       = 32,
  localparam int ADDR_W      = $clog2(BLOCKS) + $clog2(BLOCK_BYTES)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_addr,
  input  logic [31:0]       seed,
  input  logic [DLY_W-1:0]  wait_cycles,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic              wd_valid,
  input  logic              wd_ready,
  output logic [7:0]        wd_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [7:0]        rd_data,
  output logic              done,
  output logic              busy,
  output logic [ERR_W-1:0]  err_count
);

  localparam int               NSL     = (ADDR_W + 7) / 8;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [ADDR_W-1:0] byte_addr;
  logic              wr_beat, rd_beat, launch, take_snap, restore;
  logic [7:0]        prng_byte, fold_byte, pattern;
  logic              mode_q;
  logic [7:0]        fold_seed_q;
  logic [ERR_W-1:0]  err_q;
  logic [8*NSL-1:0]  addr_ext;

  mbist_seq #(
    .BLOCKS(BLOCKS), .BLOCK_BYTES(BLOCK_BYTES), .DLY_W(DLY_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wait_cycles(wait_cycles),
    .req_ready(req_ready), .wd_ready(wd_ready), .rd_valid(rd_valid),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .wd_valid(wd_valid), .rd_ready(rd_ready), .byte_addr(byte_addr),
    .wr_beat(wr_beat), .rd_beat(rd_beat), .launch(launch),
    .take_snap(take_snap), .restore(restore), .done(done), .busy(busy)
  );

  mbist_prng u_prng (
    .clk(clk), .rst_n(rst_n), .load(launch), .seed(seed),
    .take(take_snap), .restore(restore), .adv(wr_beat || rd_beat),
    .byte_o(prng_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= 1'b0;
      fold_seed_q <= '0;
    end else if (launch) begin
      mode_q      <= mode_addr;
      fold_seed_q <= seed[7:0];
    end
  end

  assign addr_ext = (8*NSL)'(byte_addr);

  always_comb begin
    fold_byte = fold_seed_q;
    for (int i = 0; i < NSL; i++) fold_byte = fold_byte ^ addr_ext[8*i +: 8];
  end

  assign pattern = mode_q ? fold_byte : prng_byte;
  assign wd_data = pattern;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                                  err_q <= '0;
    else if (launch)                                             err_q <= '0;
    else if (rd_beat && rd_data != pattern && err_q != ERR_MAX)  err_q <= err_q + 1'b1;
  end

  assign err_count = err_q;

  // R8: write byte held under back-pressure
  a_r8_wd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && !wd_ready) |=> (wd_valid && $stable(wd_data)));

  // R7: saturated count stays put until a new run
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q == ERR_MAX && !launch) |=> (err_q == ERR_MAX));

  // R7: count only grows within a run, one step at a time
  a_r7_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> (err_q >= $past(err_q) && err_q - $past(err_q) <= 1));

  // R8: count only changes on an accepted read beat
  a_r8_rd_only_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_beat && !launch) |=> $stable(err_q));

endmodule

// File: tb/test_mbist_engine.sv
`timescale 1ns/1ps
module test_mbist_engine;

  localparam int BLK = 4;
  localparam int BB  = 8;
  localparam int DW  = 4;
  localparam int EW  = 4;
  localparam int AW  = $clog2(BLK) + $clog2(BB);
  localparam int NB  = BLK * BB;

  typedef struct packed {
    logic        mode;
    logic [31:0] seed;
    logic [3:0]  wt;
    logic [5:0]  ncor;
    logic        stall;
    logic [3:0]  exp_err;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 32'h1234_5678, 4'd0, 6'd0,  1'b0, 4'd0},
    '{1'b0, 32'hdead_beef, 4'd3, 6'd2,  1'b1, 4'd2},
    '{1'b1, 32'h0000_00a5, 4'd1, 6'd5,  1'b1, 4'd5},
    '{1'b0, 32'h0bad_f00d, 4'd7, 6'd20, 1'b0, 4'd15},
    '{1'b1, 32'h0000_0000, 4'd0, 6'd0,  1'b1, 4'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          mode_addr = 1'b0;
  logic [31:0]   seed = '0;
  logic [DW-1:0] wait_cycles = '0;
  logic          req_valid, req_write, wd_valid, rd_ready, done, busy;
  logic          req_ready = 1'b0, wd_ready = 1'b0, rd_valid = 1'b0;
  logic [AW-1:0] req_addr;
  logic [7:0]    wd_data;
  logic [7:0]    rd_data = '0;
  logic [EW-1:0] err_count;

  always #4 clk = ~clk;

  mbist_engine #(.BLOCKS(BLK), .BLOCK_BYTES(BB), .DLY_W(DW), .ERR_W(EW)) i_mbist_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_addr(mode_addr), .seed(seed),
    .wait_cycles(wait_cycles), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .wd_valid(wd_valid),
    .wd_ready(wd_ready), .wd_data(wd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .done(done), .busy(busy),
    .err_count(err_count)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0]    mem     [NB];
  logic [7:0]    ref_img [NB];
  bit            stall, rd_pend, hold_w, hold_r;
  logic [7:0]    hold_data;
  logic [AW-1:0] hold_addr, rd_base;
  int cyc, ph, exp_blk, wbeats, rd_idx, cor_left, exp_wait, last_w;
  int viol_order, viol_hold, viol_wait;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (hold_w && (!wd_valid || wd_data != hold_data)) viol_hold++;
      if (hold_r && (!req_valid || req_addr != hold_addr)) viol_hold++;
      req_ready = stall ? (cyc % 3 != 0) : 1'b1;
      wd_ready  = stall ? (cyc % 2 == 0) : 1'b1;
      if (rd_pend) begin
        rd_valid = stall ? (cyc % 4 != 1) : 1'b1;
        rd_data  = mem[int'(rd_base) + rd_idx] ^ ((cor_left > 0) ? 8'h01 : 8'h00);
      end else begin
        rd_valid = stall;
        rd_data  = 8'h5a;
      end
      #1;
      hold_w    = wd_valid && !wd_ready;
      hold_data = wd_data;
      hold_r    = req_valid && !req_ready;
      hold_addr = req_addr;
      if (req_valid && req_ready) begin
        if (req_write) begin
          if (ph != 0 || int'(req_addr) != exp_blk * BB) viol_order++;
          ph = 1; wbeats = 0;
        end else begin
          if (ph != 2 || int'(req_addr) != exp_blk * BB) viol_order++;
          if (stall ? (cyc - last_w < exp_wait + 1) : (cyc - last_w != exp_wait + 1)) viol_wait++;
          ph = 3; rd_pend = 1; rd_idx = 0; rd_base = req_addr;
        end
      end
      if (wd_valid && wd_ready) begin
        if (ph != 1 || exp_blk < 0) viol_order++;
        else begin
          mem[exp_blk * BB + wbeats] = wd_data;
          wbeats++;
          if (wbeats == BB) begin ph = 2; last_w = cyc; end
        end
      end
      if (rd_valid && rd_ready) begin
        if (!rd_pend) viol_order++;
        else begin
          if (cor_left > 0) cor_left--;
          rd_idx++;
          if (rd_idx == BB) begin rd_pend = 0; ph = 0; exp_blk--; end
        end
      end
    end
  end

  // ---------------- reference pattern from R3 / R5 ----------------
  task automatic build_ref(input logic m, input logic [31:0] sd);
    logic [15:0] a, b, t, s;
    logic [31:0] k32;
    a = sd[15:0];
    b = sd[31:16];
    for (int blk = BLK - 1; blk >= 0; blk--) begin
      for (int i = 0; i < BB; i++) begin
        k32 = 32'(blk * BB + i);
        if (m) begin
          ref_img[blk * BB + i] = sd[7:0] ^ k32[7:0] ^ k32[15:8] ^ k32[23:16] ^ k32[31:24];
        end else begin
          s = a + b;
          ref_img[blk * BB + i] = s[15:8];
          t = a ^ b;
          a = ((a << 13) | (a >> 3)) ^ t ^ (t << 5);
          b = (t << 10) | (t >> 6);
        end
      end
    end
  endtask

  task automatic run(input vec_t vv, input bit poke);
    int bad;
    stall = vv.stall; cor_left = int'(vv.ncor); exp_wait = int'(vv.wt);
    exp_blk = BLK - 1; ph = 0; rd_pend = 0;
    viol_order = 0; viol_hold = 0; viol_wait = 0;
    build_ref(vv.mode, vv.seed);
    mode_addr = vv.mode; seed = vv.seed; wait_cycles = vv.wt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mode_addr = ~vv.mode; seed = ~vv.seed; wait_cycles = ~vv.wt;
    chk(busy && !done, "R1", "busy/done after start", {busy, done}, 2);
    for (int c = 0; c < 4000 && !done; c++) begin
      start = (poke && c == 20);
      @(negedge clk);
    end
    start = 1'b0;
    chk(done && !busy, "R1", "done at end of run", {done, busy}, 2);
    chk(err_count == vv.exp_err, "R7", "error count", err_count, vv.exp_err);
    bad = 0;
    for (int k = 0; k < NB; k++) if (mem[k] !== ref_img[k]) bad++;
    if (vv.mode) chk(bad == 0, "R5", "address-fold image mismatches", bad, 0);
    else         chk(bad == 0, "R3 R4", "generator image mismatches", bad, 0);
    chk(viol_order == 0 && exp_blk == -1, "R2", "burst order violations", viol_order, 0);
    chk(viol_wait == 0, "R6", "write-to-read wait violations", viol_wait, 0);
    chk(viol_hold == 0, "R8", "hold rule violations", viol_hold, 0);
  endtask

  initial begin
    #(150000 * 8);
    errors++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 during reset
    chk(!busy && !done && !req_valid && !wd_valid && !rd_ready, "R9", "outputs in reset",
        {busy, done, req_valid, wd_valid, rd_ready}, 0);
    chk(err_count == 0, "R9", "count in reset", err_count, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !req_valid, "R9", "idle after reset", {busy, done, req_valid}, 0);

    for (int v = 0; v < 5; v++) run(VECS[v], 1'b0);

    // R1: start pulse during a run is ignored; same seed reproduces the image
    run(VECS[0], 1'b1);

    // R9: reset in the middle of a run
    stall = 0; cor_left = 0; rd_pend = 0;
    mode_addr = 1'b0; seed = 32'hcafe_0042; wait_cycles = 4'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !req_valid && !wd_valid && !rd_ready, "R9", "outputs after mid-run reset",
        {busy, done, req_valid, wd_valid, rd_ready}, 0);
    chk(err_count == 0, "R9", "count after mid-run reset", err_count, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8 / R7: run again after reset with junk read data present when idle
    run(VECS[1], 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule